// File: doc/BRIEF.md
# Table-Driven Frame Time-Data Injector

This block sits in a MAC byte stream, on either the receive or the transmit side, upstream of the frame check sequence generator. It writes time information into synchronization frames as they pass through it. It does not parse any protocol. A small table of rules, loaded by software, holds the protocol knowledge. Each rule gives a match on the EtherType and on one subtype byte, with per-bit masks. It also gives the kind of time data to write and the byte position of the 64-bit field that receives it.

Three actions are available. The first overwrites the field with the current local time. The second adds a residence delay to the value already in the field: the current time minus a receive timestamp that travels with the frame. The third serves software-triggered sends. It adds the lateness of the actual send, measured against a scheduled time that also travels with the frame. Every frame passes through an 8-byte delay line. The whole field is therefore on chip at once and can be summed with full carry before its first byte leaves. Latency is fixed, and frame length and byte order never change.

Top module: `tdi_injector`

## Requirements
- R1: After reset, `out_valid` and `ofs_err` are low.
- R2: Every input byte appears on the output, with its start and end markers, exactly 9 clock cycles after it is presented. Byte order and frame length are unchanged. The bytes of one frame must arrive on consecutive cycles.
- R3: A frame that matches no enabled rule leaves the block bit-exact.
- R4: A rule matches when two comparisons both hold in every bit where the mask is 1, and mask bits of 0 are wildcards. The first comparison is the EtherType, taken from frame bytes 12 and 13 (high byte first). The second is the subtype byte at the rule's subtype offset. A rule whose enable is low never matches.
- R5: When several rules match, only the lowest-index rule acts, and the fields named by the other rules stay untouched.
- R6: Action code 0 replaces the 8 bytes starting at the field offset with the local time, most significant byte first. Offsets count from the first frame byte. The time used is the one present in the cycle after the last field byte is presented.
- R7: Action code 1 adds (local time − receive timestamp) to the field, modulo 2^64. The receive timestamp is sampled with the start marker.
- R8: Action code 2 adds (local time − scheduled time) to the field, modulo 2^64. The scheduled time is sampled with the start marker.
- R9: The addition carries across all 8 bytes of the field.
- R10: If a matching rule's field runs past the end of the frame, the frame leaves unmodified. `ofs_err` rises and stays high until reset, including across later correct frames.
- R11: A field whose last byte is the last byte of the frame is still written, and `ofs_err` stays low.
- R12: Frames sent back to back with no idle cycle are each handled on their own. Each matching frame is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one rule-table entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_en | input | 1 | Rule enable |
| cfg_act | input | 2 | 0 stamp, 1 residence add, 2 lateness add, 3 leave field as is |
| cfg_et_val | input | 16 | EtherType compare value |
| cfg_et_msk | input | 16 | EtherType compare mask (1 = compare) |
| cfg_sb_val | input | 8 | Subtype compare value |
| cfg_sb_msk | input | 8 | Subtype compare mask (1 = compare) |
| cfg_sb_ofs | input | OFS_W | Byte offset of the subtype byte |
| cfg_fld_ofs | input | OFS_W | Byte offset of the 64-bit time field |
| now_ns | input | TIME_W | Local time in nanoseconds |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Input byte |
| in_rx_ts | input | TIME_W | Receive timestamp, sampled with the start marker |
| in_sched | input | TIME_W | Scheduled send time, sampled with the start marker |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_data | output | 8 | Output byte |
| ofs_err | output | 1 | Sticky flag: a field lay beyond its frame's end |

## Verification
The bench uses the default build: four rules and a 64-bit time field, so the delay line is eight bytes deep. Four entries are enough to load two rules that overlap on one EtherType, plus one wildcard-subtype rule and one rule on a second EtherType. Those overlaps bring priority, masking and disabling within reach in a single configuration. The full-width field lets a carry run from the lowest byte to the highest. The fixed depth also puts frames whose field ends exactly on the last byte, or just past it, a short distance apart.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  localparam int unsigned OFS_W = 11;

  typedef enum logic [1:0] {
    ACT_STAMP = 2'd0,
    ACT_RESID = 2'd1,
    ACT_LATE  = 2'd2,
    ACT_KEEP  = 2'd3
  } act_e;

  typedef struct packed {
    logic             en;
    act_e             act;
    logic [15:0]      et_val;
    logic [15:0]      et_msk;
    logic [7:0]       sb_val;
    logic [7:0]       sb_msk;
    logic [OFS_W-1:0] sb_ofs;
    logic [OFS_W-1:0] fld_ofs;
  } rule_t;
endpackage

// File: rtl/tdi_rule_table.sv
module tdi_rule_table
  import tdi_pkg::*;
#(
  parameter  int NUM_RULES = 4,
  localparam int IDX_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  rule_t                       wr_rule,
  output rule_t [NUM_RULES-1:0]       rules
);
  rule_t tbl [NUM_RULES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RULES; i++) tbl[i] <= '0;
    end else if (we && (32'(idx) < NUM_RULES)) begin
      tbl[idx] <= wr_rule;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_RULES; i++) rules[i] = tbl[i];
  end
endmodule

// File: rtl/tdi_matcher.sv
module tdi_matcher
  import tdi_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int CNT_W     = OFS_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic                    in_sof,
  input  logic [7:0]              in_data,
  input  rule_t [NUM_RULES-1:0]   rules,
  output logic [CNT_W-1:0]        cnt,
  output logic                    win_vld,
  output act_e                    win_act,
  output logic [OFS_W-1:0]        win_fld
);
  logic [CNT_W-1:0]     idx;
  logic [15:0]          et_q;
  logic [1:0]           et_seen;
  logic [NUM_RULES-1:0] hit;
  logic [NUM_RULES-1:0] win_oh;

  assign idx = in_sof ? '0 : cnt;

  // byte position counter and EtherType capture
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      et_q    <= '0;
      et_seen <= '0;
    end else if (in_v) begin
      cnt <= (idx == '1) ? idx : idx + 1'b1;
      if (in_sof) et_seen <= '0;
      if (idx == CNT_W'(12)) begin
        et_q[15:8] <= in_data;
        et_seen[1] <= 1'b1;
      end
      if (idx == CNT_W'(13)) begin
        et_q[7:0]  <= in_data;
        et_seen[0] <= 1'b1;
      end
    end
  end

  // one subtype capture per rule
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic [7:0] sb_q;
    logic       sb_seen;
    always_ff @(posedge clk) begin
      if (rst) begin
        sb_q    <= '0;
        sb_seen <= 1'b0;
      end else if (in_v) begin
        if (idx == CNT_W'(rules[g].sb_ofs)) begin
          sb_q    <= in_data;
          sb_seen <= 1'b1;
        end else if (in_sof) begin
          sb_seen <= 1'b0;
        end
      end
    end
    assign hit[g] = rules[g].en && (&et_seen) && sb_seen &&
                    (((et_q ^ rules[g].et_val) & rules[g].et_msk) == 16'h0) &&
                    (((sb_q ^ rules[g].sb_val) & rules[g].sb_msk) == 8'h0);
  end

  // lowest index wins
  always_comb begin
    win_oh  = '0;
    win_vld = 1'b0;
    win_act = ACT_KEEP;
    win_fld = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_vld   = 1'b1;
        win_act   = rules[i].act;
        win_fld   = rules[i].fld_ofs;
      end
    end
  end

  // R5
  prio_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> ((((win_oh - 1'b1) & hit) == '0) && $onehot0(win_oh)));
endmodule

// File: rtl/tdi_delay_line.sv
module tdi_delay_line #(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_v,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  input  logic               wr_en,
  input  logic [8*DEPTH-1:0] wr_val,
  output logic [8*DEPTH-1:0] field,
  output logic               s0_v,
  output logic               s0_eof,
  output logic               out_v,
  output logic               out_sof,
  output logic               out_eof,
  output logic [7:0]         out_data
);
  localparam int WW = $clog2(DEPTH + 2);
  localparam logic [WW-1:0] WMAX = WW'(DEPTH + 1);

  logic [DEPTH-1:0] sv, ssof, seof;
  logic [7:0]       sd [DEPTH];
  logic [WW-1:0]    warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv      <= '0;
      ssof    <= '0;
      seof    <= '0;
      out_v   <= 1'b0;
      out_sof <= 1'b0;
      out_eof <= 1'b0;
    end else begin
      sv      <= {sv[DEPTH-2:0], in_v};
      ssof    <= {ssof[DEPTH-2:0], in_v & in_sof};
      seof    <= {seof[DEPTH-2:0], in_v & in_eof};
      out_v   <= sv[DEPTH-1];
      out_sof <= ssof[DEPTH-1];
      out_eof <= seof[DEPTH-1];
    end
  end

  // data path: bytes shift every cycle, field rewritten in flight
  always_ff @(posedge clk) begin
    sd[0]    <= in_data;
    for (int k = 1; k < DEPTH; k++)
      sd[k] <= wr_en ? wr_val[8*(k-1) +: 8] : sd[k-1];
    out_data <= wr_en ? wr_val[8*(DEPTH-1) +: 8] : sd[DEPTH-1];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_fld
    assign field[8*k +: 8] = sd[k];
  end

  assign s0_v   = sv[0];
  assign s0_eof = seof[0];

  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != WMAX) warm <= warm + 1'b1;
  end

  // R2
  fixed_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == WMAX) |-> ((out_v == $past(in_v, DEPTH + 1)) &&
                        (out_sof == $past(in_v & in_sof, DEPTH + 1))));
endmodule

// File: rtl/tdi_injector.sv
module tdi_injector
  import tdi_pkg::*;
#(
  parameter  int NUM_RULES = 4,
  parameter  int TIME_W    = 64,
  localparam int IDX_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int FLD_BYTES = TIME_W / 8,
  localparam int CNT_W     = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_act,
  input  logic [15:0]       cfg_et_val,
  input  logic [15:0]       cfg_et_msk,
  input  logic [7:0]        cfg_sb_val,
  input  logic [7:0]        cfg_sb_msk,
  input  logic [OFS_W-1:0]  cfg_sb_ofs,
  input  logic [OFS_W-1:0]  cfg_fld_ofs,
  input  logic [TIME_W-1:0] now_ns,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic [TIME_W-1:0] in_rx_ts,
  input  logic [TIME_W-1:0] in_sched,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [7:0]        out_data,
  output logic              ofs_err
);
  rule_t                 wr_rule;
  rule_t [NUM_RULES-1:0] rules;
  logic [CNT_W-1:0]      cnt;
  logic                  win_vld;
  act_e                  win_act;
  logic [OFS_W-1:0]      win_fld;
  logic [TIME_W-1:0]     field, wr_val, rx_q, sched_q;
  logic                  s0_v, s0_eof, fired, fire;
  logic [CNT_W-1:0]      fld_end;

  always_comb begin
    wr_rule         = '0;
    wr_rule.en      = cfg_en;
    wr_rule.act     = act_e'(cfg_act);
    wr_rule.et_val  = cfg_et_val;
    wr_rule.et_msk  = cfg_et_msk;
    wr_rule.sb_val  = cfg_sb_val;
    wr_rule.sb_msk  = cfg_sb_msk;
    wr_rule.sb_ofs  = cfg_sb_ofs;
    wr_rule.fld_ofs = cfg_fld_ofs;
  end

  tdi_rule_table #(.NUM_RULES(NUM_RULES)) u_tbl (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .wr_rule(wr_rule), .rules(rules)
  );

  tdi_matcher #(.NUM_RULES(NUM_RULES), .CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .in_v(in_valid), .in_sof(in_sof), .in_data(in_data),
    .rules(rules), .cnt(cnt), .win_vld(win_vld), .win_act(win_act), .win_fld(win_fld)
  );

  tdi_delay_line #(.DEPTH(FLD_BYTES)) u_dly (
    .clk(clk), .rst(rst), .in_v(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .wr_en(fire), .wr_val(wr_val), .field(field),
    .s0_v(s0_v), .s0_eof(s0_eof), .out_v(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data)
  );

  // last field byte has just entered stage 0: whole field is held
  assign fld_end = CNT_W'(win_fld) + CNT_W'(FLD_BYTES);
  assign fire    = s0_v && win_vld && !fired && (cnt == fld_end);

  always_comb begin
    case (win_act)
      ACT_STAMP: wr_val = now_ns;
      ACT_RESID: wr_val = field + (now_ns - rx_q);
      ACT_LATE:  wr_val = field + (now_ns - sched_q);
      default:   wr_val = field;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= '0;
      sched_q <= '0;
      fired   <= 1'b0;
      ofs_err <= 1'b0;
    end else begin
      if (in_valid && in_sof) begin
        rx_q    <= in_rx_ts;
        sched_q <= in_sched;
      end
      if (fire) fired <= 1'b1;
      if (in_valid && in_sof) fired <= 1'b0;
      if (s0_v && s0_eof && win_vld && !fired && !fire) ofs_err <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ofs_err |=> ofs_err);

  // R6
  stamp_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && (win_act == ACT_STAMP)) |=> (out_data == $past(now_ns[TIME_W-1 -: 8])));

  // R12
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: tb/sim_tdi_injector.sv
module sim_tdi_injector;
  localparam logic [63:0] NOW_BASE = 64'h0000_0012_3456_7000;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_en;
  logic [1:0]  cfg_idx, cfg_act;
  logic [15:0] cfg_et_val, cfg_et_msk;
  logic [7:0]  cfg_sb_val, cfg_sb_msk;
  logic [10:0] cfg_sb_ofs, cfg_fld_ofs;
  logic [63:0] now_ns, in_rx_ts, in_sched;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        ofs_err;

  int nchk = 0, nerr = 0, cyc = 0;
  bit fin = 0;

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] now_at(int c);
    return NOW_BASE + 64'(c) * 64'd8;
  endfunction
  assign now_ns = now_at(cyc);

  tdi_injector u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_act(cfg_act), .cfg_et_val(cfg_et_val), .cfg_et_msk(cfg_et_msk),
    .cfg_sb_val(cfg_sb_val), .cfg_sb_msk(cfg_sb_msk), .cfg_sb_ofs(cfg_sb_ofs),
    .cfg_fld_ofs(cfg_fld_ofs), .now_ns(now_ns), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .in_rx_ts(in_rx_ts),
    .in_sched(in_sched), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data), .ofs_err(ofs_err)
  );

  // output monitor
  logic [7:0] cap [128];
  int cap_n = 0, nsof = 0, last_eof = -1;
  int sofc [4];
  always @(negedge clk) begin
    if (out_valid) begin
      if (out_sof && nsof < 4) begin sofc[nsof] = cyc; nsof++; end
      if (out_eof) last_eof = cap_n;
      if (cap_n < 128) cap[cap_n] = out_data;
      cap_n++;
    end
  end

  logic [7:0] fr  [2][64];
  logic [7:0] exf [2][64];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mk(input int w, input int len, input logic [15:0] et, input logic [7:0] sb);
    for (int i = 0; i < len; i++) fr[w][i] = 8'(i * 13 + 5);
    fr[w][12] = et[15:8];
    fr[w][13] = et[7:0];
    fr[w][14] = sb;
    for (int i = 0; i < len; i++) exf[w][i] = fr[w][i];
  endtask

  task automatic put_fr(input int w, input int ofs, input logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      fr[w][ofs+i]  = v[63-8*i -: 8];
      exf[w][ofs+i] = v[63-8*i -: 8];
    end
  endtask

  task automatic put_ex(input int w, input int ofs, input logic [63:0] v);
    for (int i = 0; i < 8; i++) exf[w][ofs+i] = v[63-8*i -: 8];
  endtask

  function automatic logic [63:0] get64(input int base);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[63-8*i -: 8] = cap[base+i];
    return v;
  endfunction

  task automatic cmp(input int w, input int off, input int len, input string req);
    int bad = -1;
    for (int i = len - 1; i >= 0; i--) if (cap[off+i] !== exf[w][i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " byte mismatch"}, 64'(cap[off+bad]), 64'(exf[w][bad]));
  endtask

  task automatic cfg(input int idx, input bit en, input int act, input logic [15:0] et,
                     input logic [15:0] etm, input logic [7:0] sb, input logic [7:0] sbm,
                     input int sbo, input int fo);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_act = 2'(act);
    cfg_et_val = et; cfg_et_msk = etm; cfg_sb_val = sb; cfg_sb_msk = sbm;
    cfg_sb_ofs = 11'(sbo); cfg_fld_ofs = 11'(fo);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input int w, input int len, input logic [63:0] rx, input logic [63:0] sch);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = fr[w][i]; in_rx_ts = rx; in_sched = sch;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic clear_mon();
    cap_n = 0; nsof = 0; last_eof = -1;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 0);
    chk(ofs_err == 1'b0, "R1 ofs_err after reset", 64'(ofs_err), 0);
  endtask

  task automatic t_unmatched();
    int c0;
    clear_mon();
    mk(0, 48, 16'h0800, 8'h10);
    c0 = cyc + 1;
    drive(0, 48, 64'h0, 64'h0);
    idle(14);
    cmp(0, 0, 48, "R3 unmatched frame bit-exact");
    chk(cap_n == 48, "R2 length kept", 64'(cap_n), 48);
    chk(nsof == 1 && sofc[0] == c0 + 9, "R2 latency 9 cycles", 64'(sofc[0] - c0), 9);
    chk(last_eof == 47, "R2 end marker position", 64'(last_eof), 47);
  endtask

  task automatic t_stamp();
    int c0;
    logic [63:0] e;
    clear_mon();
    mk(0, 48, 16'h88F7, 8'h10);
    c0 = cyc + 1;
    e = now_at(c0 + 22 + 8);
    put_ex(0, 22, e);
    drive(0, 48, 64'h0, 64'h0);
    idle(14);
    chk(get64(22) == e, "R6 stamp value", get64(22), e);
    cmp(0, 0, 48, "R5 only rule 0 acts, bytes 30..37 untouched");
  endtask

  task automatic t_resid(input logic [7:0] sb, input logic [63:0] pre, input logic [63:0] dly,
                         input string req);
    int c0;
    logic [63:0] nf, e;
    clear_mon();
    mk(0, 48, 16'h88F7, sb);
    put_fr(0, 22, pre);
    c0 = cyc + 1;
    nf = now_at(c0 + 30);
    e = pre + dly;
    put_ex(0, 22, e);
    drive(0, 48, nf - dly, nf - 64'h7777);
    idle(14);
    chk(get64(22) == e, req, get64(22), e);
    cmp(0, 0, 48, {req, " frame"});
  endtask

  task automatic t_late();
    int c0;
    logic [63:0] nf, e;
    clear_mon();
    mk(0, 48, 16'h891D, 8'h55);
    put_fr(0, 20, 64'h10);
    c0 = cyc + 1;
    nf = now_at(c0 + 28);
    e = 64'h510;
    put_ex(0, 20, e);
    drive(0, 48, nf - 64'h9999, nf - 64'h500);
    idle(14);
    chk(get64(20) == e, "R8 lateness added", get64(20), e);
    cmp(0, 0, 48, "R8 frame");
  endtask

  task automatic t_wild();
    int c0;
    logic [63:0] e;
    clear_mon();
    mk(0, 48, 16'h88F7, 8'h02);
    c0 = cyc + 1;
    e = now_at(c0 + 38);
    put_ex(0, 30, e);
    drive(0, 48, 64'h0, 64'h0);
    idle(14);
    chk(get64(30) == e, "R4 wildcard subtype rule 3 stamps", get64(30), e);
    cmp(0, 0, 48, "R4 masked subtype leaves rules 0,1 idle");
    cfg(3, 1'b0, 0, 16'h88F7, 16'hFFFF, 8'h00, 8'h00, 14, 30);
    clear_mon();
    mk(0, 48, 16'h88F7, 8'h02);
    drive(0, 48, 64'h0, 64'h0);
    idle(14);
    cmp(0, 0, 48, "R4 disabled rule never matches");
  endtask

  task automatic t_edge();
    int c0;
    logic [63:0] e;
    clear_mon();
    mk(0, 30, 16'h88F7, 8'h20);
    c0 = cyc + 1;
    e = now_at(c0 + 30);
    put_ex(0, 22, e);
    drive(0, 30, 64'h0, 64'h0);
    idle(14);
    chk(get64(22) == e, "R11 field on last byte written", get64(22), e);
    chk(ofs_err == 1'b0, "R11 no error", 64'(ofs_err), 0);
  endtask

  task automatic t_short();
    int c0;
    logic [63:0] e;
    clear_mon();
    mk(0, 26, 16'h88F7, 8'h00);
    drive(0, 26, 64'h0, 64'h0);
    idle(14);
    cmp(0, 0, 26, "R10 short frame unmodified");
    chk(cap_n == 26, "R10 short frame length", 64'(cap_n), 26);
    chk(ofs_err == 1'b1, "R10 error raised", 64'(ofs_err), 1);
    clear_mon();
    mk(0, 48, 16'h88F7, 8'h30);
    c0 = cyc + 1;
    e = now_at(c0 + 30);
    put_ex(0, 22, e);
    drive(0, 48, 64'h0, 64'h0);
    idle(14);
    cmp(0, 0, 48, "R10 later frame still processed");
    chk(ofs_err == 1'b1, "R10 error sticky", 64'(ofs_err), 1);
  endtask

  task automatic t_b2b();
    int c0;
    logic [63:0] ea, eb, nb;
    clear_mon();
    mk(0, 40, 16'h88F7, 8'h40);
    mk(1, 40, 16'h88F7, 8'h08);
    put_fr(1, 22, 64'h0000_0000_0000_0100);
    c0 = cyc + 1;
    ea = now_at(c0 + 30);
    nb = now_at(c0 + 40 + 30);
    eb = 64'h0000_0000_0000_0100 + 64'h444;
    put_ex(0, 22, ea);
    put_ex(1, 22, eb);
    drive(0, 40, 64'h0, 64'h0);
    drive(1, 40, nb - 64'h444, 64'h0);
    idle(14);
    chk(cap_n == 80 && nsof == 2, "R12 both frames out", 64'(cap_n), 80);
    chk(sofc[1] == c0 + 40 + 9, "R12 second frame latency", 64'(sofc[1] - c0), 49);
    cmp(0, 0, 40, "R12 first frame stamped");
    cmp(1, 40, 40, "R12 second frame residence");
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0; cfg_act = '0;
    cfg_et_val = '0; cfg_et_msk = '0; cfg_sb_val = '0; cfg_sb_msk = '0;
    cfg_sb_ofs = '0; cfg_fld_ofs = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    in_rx_ts = '0; in_sched = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg(0, 1'b1, 0, 16'h88F7, 16'hFFFF, 8'h00, 8'h0F, 14, 22);
    cfg(1, 1'b1, 1, 16'h88F7, 16'hFFFF, 8'h08, 8'h0F, 14, 22);
    cfg(2, 1'b1, 2, 16'h891D, 16'hFFFF, 8'h00, 8'h00, 14, 20);
    cfg(3, 1'b1, 0, 16'h88F7, 16'hFFFF, 8'h00, 8'h00, 14, 30);
    idle(2);
    t_unmatched();
    t_stamp();
    t_resid(8'h08, 64'h0000_0000_0000_1000, 64'h1234_5678, "R7 residence added");
    t_resid(8'hF8, 64'h00FF_FFFF_FFFF_FFF0, 64'h20, "R9 carry through all bytes");
    t_late();
    t_wild();
    t_edge();
    t_b2b();
    t_short();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1ms;
    if (!fin) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule